// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Tracker

This block sits in front of the command pins of a four-bank SDRAM and makes sure that every row activation and column access keeps its minimum spacing. A scheduler offers one command per cycle on a valid/ready handshake, using the usual active-low select, row-strobe, column-strobe and write-enable encoding plus bank and address fields. The tracker keeps one open/closed flag per bank and three kinds of interval counters. A per-bank counter covers activate to column access. A second per-bank counter covers activate to activate in the same bank. One shared counter covers activate to activate across banks.

A legal command whose intervals have all run out is accepted. It then appears unchanged on the registered memory-side command bus one cycle later. A legal command that is still too early is held by dropping ready, and the memory-side bus carries NOP meanwhile. A column access to a closed bank, or an activation of a bank that is already open, cannot become legal by waiting. Such a command is accepted at once and discarded, and an error pulse is raised in its place. The intervals are given as picosecond minimums and a clock period, and the block converts them to cycles at elaboration.

Top module: `sdr_act_tracker`

## Requirements
- R1: After reset every bank is closed, the memory-side bus carries NOP (select low, the three strobes high, bank and address zero) and the error flag is low.
- R2: Commands decode from {cs_n, ras_n, cas_n, we_n} only while cke is high: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0111 NOP; any other code with cs_n low (for example 0001) is accepted immediately and forwarded unchanged.
- R3: Each interval in cycles is the picosecond minimum divided by the clock period, rounded up (65000 ps at 7500 ps gives 9 cycles, 20000 ps gives 3, 15000 ps gives 2).
- R4: A read or write to an open bank whose activation was accepted at edge T is accepted no earlier than edge T + tRCD cycles, and exactly then if offered earlier.
- R5: An activation of a closed bank is accepted no earlier than tRC cycles after the previous accepted activation of that same bank.
- R6: An activation is accepted no earlier than tRRD cycles after the previous accepted activation of any bank.
- R7: A read or write to a closed bank is accepted in the cycle it is offered, is not forwarded (the bus shows NOP), and the error flag is high for exactly the following cycle.
- R8: An activation of a bank that already has an open row is accepted at once, not forwarded, and flagged as an error like R7.
- R9: A precharge is always accepted in the cycle it is offered and is forwarded; it closes its bank, or every bank when address bit 10 is high.
- R10: An accepted command appears on the memory-side bus one cycle after acceptance; every cycle without a forwarded command (idle, stalled, cke low, cs_n high) shows NOP, and a command offered with cke low or cs_n high changes no bank state.
- R11: Timing on one bank never delays a column access to another bank whose own tRCD has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The offered command is accepted at this edge |
| cmd_cke | input | 1 | Clock enable qualifying the command |
| cmd_cs_n | input | 1 | Chip select, active low |
| cmd_ras_n | input | 1 | Row strobe, active low |
| cmd_cas_n | input | 1 | Column strobe, active low |
| cmd_we_n | input | 1 | Write enable, active low |
| cmd_bank | input | BANK_W | Bank address |
| cmd_addr | input | ROW_W | Row or column address; bit 10 selects all banks on precharge |
| dram_cs_n | output | 1 | Forwarded chip select |
| dram_ras_n | output | 1 | Forwarded row strobe |
| dram_cas_n | output | 1 | Forwarded column strobe |
| dram_we_n | output | 1 | Forwarded write enable |
| dram_bank | output | BANK_W | Forwarded bank |
| dram_addr | output | ROW_W | Forwarded address |
| cmd_err | output | 1 | One-cycle pulse for a discarded illegal command |

## Verification
The bench aims at the exact acceptance edge of a read offered right behind its activation; a counter loaded one off would let the read out on the second edge or hold it to the fourth. Two activations to different banks back to back probe the shared spacing, and a re-activation straight after precharge probes the same-bank spacing. A design that reset only one of these counters, or mixed them up, would accept too early. Precharge-all followed by reads to every bank catches a design that ignores address bit 10. A command with clock enable low, followed by a read to the same bank, would expose a decoder that opens banks without qualification.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

  typedef enum logic [2:0] {
    K_NOP, K_ACT, K_RD, K_WR, K_PRE, K_OTHER
  } cmd_kind_e;

  function automatic cmd_kind_e decode_cmd(input logic cke, input logic cs_n,
                                           input logic ras_n, input logic cas_n,
                                           input logic we_n);
    if (!cke || cs_n) return K_NOP;
    case ({ras_n, cas_n, we_n})
      3'b111:  return K_NOP;
      3'b011:  return K_ACT;
      3'b101:  return K_RD;
      3'b100:  return K_WR;
      3'b010:  return K_PRE;
      default: return K_OTHER;
    endcase
  endfunction

  // Minimum time to whole cycles, rounding up.
  function automatic int ps_to_cyc(input int t_ps, input int tck_ps);
    return (t_ps + tck_ps - 1) / tck_ps;
  endfunction

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/bank_tmr.sv
module bank_tmr #(
  parameter int RCD_CYC = 3,
  parameter int RC_CYC  = 9,
  parameter int CW      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  input  logic cas_go,
  input  logic pre_go,
  output logic open_o,
  output logic rcd_ok_o,
  output logic rc_ok_o
);

  logic          open_q;
  logic [CW-1:0] rcd_q;
  logic [CW-1:0] rc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      rc_q   <= '0;
    end else begin
      if (act_go) begin
        open_q <= 1'b1;
        rcd_q  <= CW'(RCD_CYC - 1);
        rc_q   <= CW'(RC_CYC - 1);
      end else begin
        if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
        if (rc_q  != '0) rc_q  <= rc_q  - 1'b1;
        if (pre_go) open_q <= 1'b0;
      end
    end
  end

  assign open_o   = open_q;
  assign rcd_ok_o = (rcd_q == '0);
  assign rc_ok_o  = (rc_q == '0);

  // R8
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> (!open_q && rc_q == '0));
  // R4
  cas_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_go |-> (open_q && rcd_q == '0));
  // R9
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go |=> !open_q);

endmodule

// File: rtl/rrd_tmr.sv
module rrd_tmr #(
  parameter int RRD_CYC = 2,
  parameter int CW      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_any,
  output logic rrd_ok_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (act_any)      cnt_q <= CW'(RRD_CYC - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign rrd_ok_o = (cnt_q == '0);

  // R6
  rrd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_any |-> cnt_q == '0);

endmodule

// File: rtl/sdr_act_tracker.sv
module sdr_act_tracker
  import sdr_trk_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 13,
  parameter int ALL_BIT     = 10,
  parameter int TCK_PS      = 7500,
  parameter int TRCD_PS     = 20000,
  parameter int TRC_PS      = 65000,
  parameter int TRRD_PS     = 15000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_cke,
  input  logic              cmd_cs_n,
  input  logic              cmd_ras_n,
  input  logic              cmd_cas_n,
  input  logic              cmd_we_n,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_addr,
  output logic              dram_cs_n,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [BANK_W-1:0] dram_bank,
  output logic [ROW_W-1:0]  dram_addr,
  output logic              cmd_err
);

  localparam int NBANK    = 1 << BANK_W;
  localparam int TRCD_CYC = (ps_to_cyc(TRCD_PS, TCK_PS) < 1) ? 1 : ps_to_cyc(TRCD_PS, TCK_PS);
  localparam int TRC_CYC  = (ps_to_cyc(TRC_PS, TCK_PS) < 1) ? 1 : ps_to_cyc(TRC_PS, TCK_PS);
  localparam int TRRD_CYC = (ps_to_cyc(TRRD_PS, TCK_PS) < 1) ? 1 : ps_to_cyc(TRRD_PS, TCK_PS);
  localparam int MAX_CYC  = (TRC_CYC > TRCD_CYC) ? TRC_CYC : TRCD_CYC;
  localparam int BCW      = cnt_width(MAX_CYC);
  localparam int RCW      = cnt_width(TRRD_CYC);

  cmd_kind_e        kind;
  logic [NBANK-1:0] open_vec, rcd_ok_vec, rc_ok_vec;
  logic [NBANK-1:0] act_go, cas_go, pre_go;
  logic             rrd_ok;
  logic             is_cas, illegal, timing_ok, fire, grant, fwd;
  logic             out_nop;

  assign kind   = decode_cmd(cmd_cke, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n);
  assign is_cas = (kind == K_RD) || (kind == K_WR);

  always_comb begin
    illegal   = 1'b0;
    timing_ok = 1'b1;
    if (is_cas) begin
      illegal   = !open_vec[cmd_bank];
      timing_ok = rcd_ok_vec[cmd_bank];
    end else if (kind == K_ACT) begin
      illegal   = open_vec[cmd_bank];
      timing_ok = rc_ok_vec[cmd_bank] && rrd_ok;
    end
  end

  assign cmd_ready = illegal || timing_ok;
  assign fire      = cmd_valid && cmd_ready;
  assign grant     = fire && !illegal;
  assign fwd       = grant && (kind != K_NOP);

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic hit;
      assign hit       = (cmd_bank == BANK_W'(b));
      assign act_go[b] = grant && (kind == K_ACT) && hit;
      assign cas_go[b] = grant && is_cas && hit;
      assign pre_go[b] = grant && (kind == K_PRE) && (hit || cmd_addr[ALL_BIT]);

      bank_tmr #(.RCD_CYC(TRCD_CYC), .RC_CYC(TRC_CYC), .CW(BCW)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_go  (act_go[b]),
        .cas_go  (cas_go[b]),
        .pre_go  (pre_go[b]),
        .open_o  (open_vec[b]),
        .rcd_ok_o(rcd_ok_vec[b]),
        .rc_ok_o (rc_ok_vec[b])
      );
    end
  endgenerate

  rrd_tmr #(.RRD_CYC(TRRD_CYC), .CW(RCW)) i_rrd (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_any (|act_go),
    .rrd_ok_o(rrd_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !fwd) begin
      {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} <= 4'b0111;
      dram_bank <= '0;
      dram_addr <= '0;
    end else begin
      {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} <= {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
      dram_bank <= cmd_bank;
      dram_addr <= cmd_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= fire && illegal;
  end

  assign out_nop = ({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == 4'b0111);

  // R10
  stall_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> out_nop);
  // R7
  err_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> out_nop);
  // R9
  pre_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && kind == K_PRE) |-> cmd_ready);
  // R6
  one_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_go));

endmodule

// File: tb/test_sdr_act_tracker.sv
`timescale 1ns/1ps
module test_sdr_act_tracker;

  localparam int TCK = 7500, T_RCD = 20000, T_RC = 65000, T_RRD = 15000;
  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_PRE = 4'b0010, P_REF = 4'b0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_cke = 1'b1;
  logic [3:0] pins = P_NOP;
  logic [1:0] cmd_bank = '0;
  logic [12:0] cmd_addr = '0;
  logic d_cs, d_ras, d_cas, d_we, cmd_err;
  logic [1:0] d_bank;
  logic [12:0] d_addr;

  always #2.5 clk = ~clk;

  sdr_act_tracker i_sdr_act_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_cke(cmd_cke), .cmd_cs_n(pins[3]), .cmd_ras_n(pins[2]),
    .cmd_cas_n(pins[1]), .cmd_we_n(pins[0]), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .dram_cs_n(d_cs), .dram_ras_n(d_ras),
    .dram_cas_n(d_cas), .dram_we_n(d_we), .dram_bank(d_bank),
    .dram_addr(d_addr), .cmd_err(cmd_err)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int c_rcd, c_rc, c_rrd;
  int last_act[4];
  int last_any = -1000;
  bit opn[4];

  typedef struct { logic [3:0] p; logic [1:0] b; logic [12:0] a; logic e; string req; } exp_t;
  exp_t q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int to_cyc(int t);
    int c = 0;
    while (c * TCK < t) c++;
    return c;
  endfunction

  function automatic int imax(int x, int y);
    return (x > y) ? x : y;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] p, input logic k, input logic [1:0] b,
                       input logic [12:0] a, input string req);
    int now, exp_edge, acc;
    bit err, fwd, is_nop;
    exp_t it;
    @(negedge clk);
    pins = p; cmd_cke = k; cmd_bank = b; cmd_addr = a; cmd_valid = 1'b1;
    now = cyc; exp_edge = now; err = 0; fwd = 1;
    is_nop = !k || p[3] || p == P_NOP;
    if (is_nop) fwd = 0;
    else if (p == P_RD || p == P_WR) begin
      if (!opn[b]) begin err = 1; fwd = 0; end
      else exp_edge = imax(now, last_act[b] + c_rcd);
    end else if (p == P_ACT) begin
      if (opn[b]) begin err = 1; fwd = 0; end
      else exp_edge = imax(now, imax(last_act[b] + c_rc, last_any + c_rrd));
    end
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    acc = cyc;
    check(acc == exp_edge, req, "accept edge", acc, exp_edge);
    if (!is_nop && p == P_ACT && !err) begin
      last_act[b] = acc; last_any = acc; opn[b] = 1;
    end
    if (!is_nop && p == P_PRE) begin
      if (a[10]) for (int i = 0; i < 4; i++) opn[i] = 0;
      else opn[b] = 0;
    end
    if (err || fwd) begin
      it.p = fwd ? p : P_NOP; it.b = fwd ? b : 2'd0; it.a = fwd ? a : 13'd0;
      it.e = err; it.req = req;
      q.push_back(it);
    end
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    cmd_valid = 1'b0; pins = P_NOP;
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done && ({d_cs, d_ras, d_cas, d_we} != P_NOP || cmd_err)) begin
      if (q.size() == 0) begin
        check(0, "R10", "unexpected output pins", {d_cs, d_ras, d_cas, d_we}, P_NOP);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({d_cs, d_ras, d_cas, d_we} == e.p, e.req, "output pins",
              {d_cs, d_ras, d_cas, d_we}, e.p);
        check(d_bank == e.b && d_addr == e.a, e.req, "output bank/addr",
              {d_bank, d_addr}, {e.b, e.a});
        check(cmd_err == e.e, e.req, "error flag", cmd_err, e.e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin last_act[i] = -1000; opn[i] = 0; end
    c_rcd = to_cyc(T_RCD); c_rc = to_cyc(T_RC); c_rrd = to_cyc(T_RRD);
    // R3 rounding restated in the bench
    check(c_rcd == 3 && c_rc == 9 && c_rrd == 2, "R3", "rounded cycles",
          c_rc, 9);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({d_cs, d_ras, d_cas, d_we} == P_NOP && d_bank == 0 && d_addr == 0,
          "R1", "reset bus", {d_cs, d_ras, d_cas, d_we}, P_NOP);
    check(cmd_err == 0, "R1", "reset error flag", cmd_err, 0);
    issue(P_RD,  1, 2'd0, 13'd4, "R1");        // closed after reset
    issue(P_ACT, 1, 2'd0, 13'h155, "R2");
    issue(P_ACT, 1, 2'd1, 13'h0A7, "R6");
    issue(P_RD,  1, 2'd0, 13'd8, "R4");
    issue(P_WR,  1, 2'd1, 13'd12, "R11");
    issue(P_ACT, 1, 2'd0, 13'h022, "R8");
    issue(P_PRE, 1, 2'd0, 13'd0, "R9");
    issue(P_ACT, 1, 2'd0, 13'h033, "R5 R3");
    issue(P_ACT, 1, 2'd2, 13'h044, "R6");
    issue(P_RD,  1, 2'd2, 13'd2, "R4");
    issue(P_RD,  1, 2'd1, 13'd6, "R11");
    idle(12);
    issue(P_WR,  1, 2'd0, 13'd3, "R4");
    issue(P_PRE, 1, 2'd3, 13'h400, "R9");
    issue(P_RD,  1, 2'd1, 13'd1, "R9");
    issue(P_WR,  1, 2'd2, 13'd1, "R9");
    issue(P_RD,  1, 2'd5 & 2'd3, 13'd9, "R7");
    issue(P_ACT, 0, 2'd3, 13'h011, "R10");
    issue(P_RD,  1, 2'd3, 13'd0, "R10");
    issue(4'b1011, 1, 2'd3, 13'h012, "R10");
    issue(P_WR,  1, 2'd3, 13'd0, "R10");
    issue(P_REF, 1, 2'd0, 13'd0, "R2");
    issue(P_ACT, 1, 2'd3, 13'h099, "R5");
    issue(P_RD,  1, 2'd3, 13'd5, "R4");
    idle(4);
    check(q.size() == 0, "R10", "pending expected outputs", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule